// File: doc/BRIEF.md
# 100BASE-X Receive Link Qualifier

This block decides whether a 100 Mb/s fibre or copper receive link may carry traffic. Line energy has to be present without a break for a programmable number of clock cycles (about 500 µs in the field) before the link is called ready. A ready link then waits for a go-ahead from the autonegotiation logic, or moves on at once when autonegotiation is configured off, and only then is it declared up. While the link is not up, a single gate output holds the transmit and receive datapaths idle.

The block also folds its own up indication together with a 10 Mb/s link indication from elsewhere in the chip. It drives an LED with the live result and a status bit for management. The status bit holds a failure until it is read: it latches low on any drop of the combined link and takes the live value again when a read strobe arrives.

Top module: `fx_link_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `link_ready`, `link_up`, `dp_en` and `stat_link` are all 0.
- R2: From the down state, `link_ready` rises at the edge where `sig_det` has been sampled high on QUAL_CYCLES consecutive edges. It does not rise at any earlier edge.
- R3: A single low sample of `sig_det` during qualification restarts the count from zero.
- R4: While ready with `an_off` low, the block stays ready as long as `an_go` is low. At the first edge with `an_go` high it moves to up (`link_up`=1, `link_ready`=0).
- R5: With `an_off` high, a ready link moves to up at the next edge whatever the value of `an_go`.
- R6: A low sample of `sig_det` in the ready or up state returns the block to down at that edge.
- R7: A low sample of `dsc_lock` in the up state returns the block to down at that edge. `dsc_lock` has no effect in the ready state.
- R8: `dp_en` is 1 exactly when `link_up` is 1.
- R9: `led_link` equals `link_up` OR `ten_link` in the same cycle, with no register in between.
- R10: When the combined link (`link_up` OR `ten_link`) is sampled low at an edge with `rd_stb` low, `stat_link` is 0 after that edge. It then stays 0 until an edge with `rd_stb` high.
- R11: At an edge with `rd_stb` high, `stat_link` takes the combined link value sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_det | input | 1 | Line energy present |
| dsc_lock | input | 1 | Descrambler is locked |
| an_go | input | 1 | Go-ahead from autonegotiation |
| an_off | input | 1 | Autonegotiation configured off |
| ten_link | input | 1 | 10 Mb/s link status from another block |
| rd_stb | input | 1 | Status read strobe, one cycle per read |
| link_ready | output | 1 | Link qualified, waiting to go up |
| link_up | output | 1 | 100 Mb/s link up |
| dp_en | output | 1 | Transmit/receive datapath enable |
| stat_link | output | 1 | Latched-low combined link status |
| led_link | output | 1 | Live combined link for the LED |

## Verification
The clash of interest is a status read that lands on the same edge as a link failure. The bench drives a loss of `sig_det` while the link is up, `ten_link` is low and `rd_stb` is high. That read has to return 1, because the link was still up when it was sampled. The very next edge, with no read, has to latch the bit to 0, and a later read while the link is down has to keep it at 0. The qualification counter is swept over every run length of `sig_det` around the threshold, with and without a single-cycle gap.

// File: rtl/lm_pkg.sv
// Shared types for the 100BASE-X link qualifier.
// Assumes: three link states are enough; encodings are internal only.
package lm_pkg;

    typedef enum logic [1:0] {
        LS_DOWN  = 2'd0,
        LS_READY = 2'd1,
        LS_UP    = 2'd2
    } lm_state_t;

endpackage

// File: rtl/lm_qual_timer.sv
// Counts consecutive cycles of line energy while the link is down.
// Assumes: run is already the AND of energy and the down state; any gap
// in run clears the count. done pulses on the cycle that completes the run.
module lm_qual_timer #(
    parameter int unsigned QUAL_CYCLES = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int unsigned CW   = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // completion is seen combinationally so the state moves on this edge
    assign done = run && (cnt_q == LAST);

    // advance while energy persists, restart from zero on any gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_PASS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                              // R2
    AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !done);                                             // R3

endmodule

// File: rtl/lm_fsm.sv
// Link state machine: down -> ready -> up, with a return to down on loss.
// Assumes: qual_done comes from lm_qual_timer; an_off is quasi-static.
// The datapath gate is registered from the next state so it tracks up.
module lm_fsm
    import lm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_det,
    input  logic      dsc_lock,
    input  logic      an_go,
    input  logic      an_off,
    input  logic      qual_done,
    output lm_state_t state_o,
    output logic      in_down,
    output logic      dp_en
);
    lm_state_t state_q, state_d;
    logic      dp_en_q;

    // next-state choice from energy, lock and autonegotiation inputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_DOWN: begin
                if (qual_done) state_d = LS_READY;
            end
            LS_READY: begin
                if (!sig_det)              state_d = LS_DOWN;
                else if (an_off || an_go)  state_d = LS_UP;
            end
            LS_UP: begin
                if (!sig_det || !dsc_lock) state_d = LS_DOWN;
            end
            default: state_d = LS_DOWN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_DOWN;
        else        state_q <= state_d;
    end

    // datapath gate register, open only in the up state
    always_ff @(posedge clk) begin
        if (!rst_n) dp_en_q <= 1'b0;
        else        dp_en_q <= (state_d == LS_UP);
    end

    assign state_o = state_q;
    assign in_down = (state_q == LS_DOWN);
    assign dp_en   = dp_en_q;

    AST_SIG_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LS_DOWN && !sig_det) |=> state_q == LS_DOWN);    // R6
    AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_UP && !dsc_lock) |=> state_q == LS_DOWN);     // R7
    AST_AN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_READY && sig_det && !an_go && !an_off)
        |=> state_q == LS_READY);                                    // R4
    AST_AN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_READY && sig_det && an_off)
        |=> state_q == LS_UP);                                       // R5

endmodule

// File: rtl/lm_status.sv
// Merges the 100 Mb/s up indication with the 10 Mb/s link into a live LED
// drive and a latched-low status bit cleared to the live value on read.
// Assumes: rd_stb is one cycle wide per management read.
module lm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic ten_link,
    input  logic rd_stb,
    output logic stat_link,
    output logic led_link
);
    logic live;
    logic stat_q;

    // live combined link
    assign live     = link_up | ten_link;
    assign led_link = live;

    // latch failures low; a read reloads the live value
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (rd_stb) stat_q <= live;
        else if (!live)  stat_q <= 1'b0;
    end

    assign stat_link = stat_q;

    AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && !rd_stb) |=> !stat_q);                             // R10
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q && !rd_stb) |=> !stat_q);                           // R10
    AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> stat_q == $past(live));                           // R11

endmodule

// File: rtl/fx_link_mon.sv
// Top of the 100BASE-X receive link qualifier.
// Assumes: all inputs are synchronous to clk; QUAL_CYCLES is the number of
// clk cycles of unbroken energy needed to qualify (500 us at 125 MHz default).
module fx_link_mon
    import lm_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_det,
    input  logic dsc_lock,
    input  logic an_go,
    input  logic an_off,
    input  logic ten_link,
    input  logic rd_stb,
    output logic link_ready,
    output logic link_up,
    output logic dp_en,
    output logic stat_link,
    output logic led_link
);
    lm_state_t state;
    logic      in_down;
    logic      qual_done;

    lm_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sig_det && in_down),
        .done  (qual_done)
    );

    lm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_det   (sig_det),
        .dsc_lock  (dsc_lock),
        .an_go     (an_go),
        .an_off    (an_off),
        .qual_done (qual_done),
        .state_o   (state),
        .in_down   (in_down),
        .dp_en     (dp_en)
    );

    assign link_ready = (state == LS_READY);
    assign link_up    = (state == LS_UP);

    lm_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .ten_link  (ten_link),
        .rd_stb    (rd_stb),
        .stat_link (stat_link),
        .led_link  (led_link)
    );

    AST_GATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dp_en == link_up);                                           // R8
    AST_READY_NEEDS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_ready) |-> $past(sig_det));                       // R2

endmodule

// File: tb/fx_link_mon_test.sv
`timescale 1ns/1ps
module fx_link_mon_test;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_det = 1'b0, dsc_lock = 1'b1, an_go = 1'b0, an_off = 1'b0;
    logic ten_link = 1'b0, rd_stb = 1'b0;
    logic link_ready, link_up, dp_en, stat_link, led_link;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fx_link_mon #(.QUAL_CYCLES(Q)) uut (
        .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .dsc_lock(dsc_lock),
        .an_go(an_go), .an_off(an_off), .ten_link(ten_link), .rd_stb(rd_stb),
        .link_ready(link_ready), .link_up(link_up), .dp_en(dp_en),
        .stat_link(stat_link), .led_link(led_link)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // bring the link from down to up with autonegotiation go-ahead
    task automatic go_up;
        sig_det = 1'b1; dsc_lock = 1'b1; an_off = 1'b0; an_go = 1'b1;
        for (int k = 0; k < Q + 1; k++) tick();
        an_go = 1'b0;
    endtask

    task automatic go_down;
        sig_det = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 ready", link_ready, 0); chk("R1 up", link_up, 0);
        chk("R1 dp_en", dp_en, 0);      chk("R1 stat", stat_link, 0);
        rst_n = 1'b1;

        // R2: sweep run lengths up to past the threshold
        for (int len = 1; len <= Q + 2; len++) begin
            sig_det = 1'b1;
            for (int k = 1; k <= len; k++) begin
                tick();
                chk("R2 ready vs run length", link_ready, (k >= Q) ? 1 : 0);
            end
            go_down();
            chk("R6 down after energy loss", link_ready, 0);
        end

        // R3: a one-cycle gap at every position restarts qualification
        for (int gap = 1; gap < Q; gap++) begin
            sig_det = 1'b1;
            for (int k = 0; k < gap; k++) tick();
            sig_det = 1'b0; tick();
            sig_det = 1'b1;
            for (int k = 1; k <= Q; k++) begin
                tick();
                chk("R3 restart after gap", link_ready, (k == Q) ? 1 : 0);
            end
            go_down();
        end

        // R4: wait in ready without go-ahead; R7: lock ignored in ready
        sig_det = 1'b1; an_go = 1'b0;
        for (int k = 0; k < Q; k++) tick();
        dsc_lock = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R4 holds ready", link_ready, 1);
            chk("R7 lock ignored in ready", link_up, 0);
        end
        dsc_lock = 1'b1; an_go = 1'b1; tick();
        chk("R4 up on go", link_up, 1); chk("R4 not ready", link_ready, 0);
        chk("R8 gate open", dp_en, 1);
        an_go = 1'b0;
        dsc_lock = 1'b0; tick();
        chk("R7 lock loss", link_up, 0); chk("R8 gate shut", dp_en, 0);
        dsc_lock = 1'b1; go_down();

        // R5: bypass with and without go-ahead
        for (int g = 0; g < 2; g++) begin
            an_off = 1'b1; an_go = g[0]; sig_det = 1'b1;
            for (int k = 0; k < Q; k++) tick();
            chk("R5 ready first", link_ready, 1);
            tick();
            chk("R5 bypass up", link_up, 1);
            go_down();
            chk("R6 up to down", link_up, 0);
            chk("R8 gate follows", dp_en, 0);
        end
        an_off = 1'b0; an_go = 1'b0;

        // R9: live LED over all combinations
        for (int t = 0; t < 2; t++) begin
            if (t == 1) go_up();
            for (int l = 0; l < 2; l++) begin
                ten_link = l[0]; #1;
                chk("R9 led", led_link, (t | l));
            end
        end
        ten_link = 1'b0;

        // R11: read while up; then read on the failure edge
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk("R11 read live up", stat_link, 1);
        rd_stb = 1'b1; sig_det = 1'b0; tick(); rd_stb = 1'b0;
        chk("R11 read on fail edge", stat_link, 1);
        chk("R6 fell on same edge", link_up, 0);
        tick();
        chk("R10 latch low", stat_link, 0);
        go_up();
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10 stays low while up", stat_link, 0);
        end
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk("R11 read clears to live", stat_link, 1);
        // R10 via 10M path: drop 100M while 10M up keeps status
        ten_link = 1'b1; go_down();
        chk("R10 ten link keeps high", stat_link, 1);
        ten_link = 1'b0; tick();
        chk("R10 combined drop", stat_link, 0);
        rd_stb = 1'b1; tick(); rd_stb = 1'b0;
        chk("R11 read while down", stat_link, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule